// File: doc/BRIEF.md
# Escape-Count Sized Depth Miss Controller

This block handles misses for a depth cache whose backing store holds each depth block in compressed form, at a size that varies from block to block. An on-chip table keeps one small escape count per block. The count sets how many bus beats the stored form of that block occupies. External reads and write-backs are therefore sized to the exact number of beats needed, and never to the worst case.

For each miss, the cache supplies the requested block index, the index of the block it evicts, and the evicted block's raw data. The controller keeps the evicted block in a staging buffer and looks up the requested block's escape count. It then reads exactly the right number of beats from memory. The payload goes to an external decompressor, or straight to the cache when the block is stored raw, and the filled line is delivered. Only after that does the controller send the staged block to an external compressor. It writes the result back with an exactly sized burst and stores the new escape count in the table in the same cycle. A second miss is not taken until that write-back has finished.

Top module: `ecdc_ctrl`

## Requirements
- R1: After the synchronous reset is released, the controller sets every table entry to the raw-storage code (escape count 7). While it does this, `miss_ready` stays low for exactly NBLK (16) cycles. Blocks that have never been written are then read at full size.
- R2: A miss is taken on a cycle where both `miss_valid` and `miss_ready` are high. `miss_ready` then stays low until the last write-back beat has been accepted.
- R3: The read request for a miss has `mem_req_write`=0 and `mem_req_blk` equal to the missed block. Its length is the one given by R4 for that block's stored escape count. It delivers that many beats of `mem_rd_data`.
- R4: Burst length in beats for escape count e is min(4, ceil((32 + 16·e)/32)). The raw-storage code 7 always gives 4 beats. Counts 0..7 therefore give 1,2,2,3,3,4,4,4.
- R5: For e below 7, the decompressor receives `dec_esc`=e and `dec_data`. In `dec_data`, read beat k sits at bits [32k+31:32k] and unread beats are zero. `fill_data` then equals the returned `dec_out`.
- R6: For e equal to 7, there is no decompressor handshake, and `fill_data` equals the four read beats packed as in R5.
- R7: `fill_valid` is a single-cycle pulse with `fill_blk` equal to the missed block. The compressor request for the evicted block comes only after this pulse.
- R8: The compressor receives the evicted block's data. The write request that follows has `mem_req_write`=1, `mem_req_blk` equal to the evicted block, and the R4 length for the returned `cmp_esc`. The table takes that count when the request is accepted, so the next read of that block uses the new length.
- R9: Write beats go out lowest beat first. Beat k is bits [32k+31:32k] of `cmp_out`, or of the evicted data itself when `cmp_esc` is 7.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its block, length and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Controller can take a miss |
| miss_blk | input | 4 | Requested block index |
| vict_blk | input | 4 | Evicted block index |
| vict_data | input | 128 | Evicted block raw data |
| fill_valid | output | 1 | Filled line pulse |
| fill_blk | output | 4 | Block index of filled line |
| fill_data | output | 128 | Filled line data |
| mem_req_valid | output | 1 | Burst request valid |
| mem_req_ready | input | 1 | Burst request accepted |
| mem_req_write | output | 1 | 1 = write burst, 0 = read burst |
| mem_req_blk | output | 4 | Block index of burst |
| mem_req_len | output | 3 | Burst length in beats |
| mem_rd_valid | input | 1 | Read beat valid |
| mem_rd_data | input | 32 | Read beat data |
| mem_wr_valid | output | 1 | Write beat valid |
| mem_wr_ready | input | 1 | Write beat accepted |
| mem_wr_data | output | 32 | Write beat data |
| dec_valid | output | 1 | Decompressor request valid |
| dec_ready | input | 1 | Decompressor request accepted |
| dec_esc | output | 3 | Escape count of payload |
| dec_data | output | 128 | Compressed payload, zero padded |
| dec_done | input | 1 | Decompressor result valid |
| dec_out | input | 128 | Decompressed block |
| cmp_valid | output | 1 | Compressor request valid |
| cmp_ready | input | 1 | Compressor request accepted |
| cmp_data | output | 128 | Block to compress |
| cmp_done | input | 1 | Compressor result valid |
| cmp_esc | input | 3 | Escape count of result |
| cmp_out | input | 128 | Compressed payload |

## Verification
The bench uses the default parameters: 32-bit beats, four-beat blocks, a 16-entry table, a 3-bit escape count, a 32-bit header and 16-bit escape records. With these values the whole escape range is reachable in a few misses. That covers the one-beat minimum, the two counts that share each middle length, the count 6 that reaches the four-beat cap while still compressed, and the raw code that bypasses the decompressor. The small table also keeps the post-reset sweep short enough to measure cycle by cycle. The miss sequence reuses evicted blocks as later requests, including one miss whose victim is its own requested block, so each written-back length and count is read again. The memory model adds request stalls and gaps between beats.

// File: rtl/ecdc_pkg.sv
package ecdc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOOK,
    ST_RD_REQ,
    ST_RD_DAT,
    ST_DEC_REQ,
    ST_DEC_WAIT,
    ST_FILL,
    ST_CMP_REQ,
    ST_CMP_WAIT,
    ST_WR_REQ,
    ST_WR_DAT
  } ctl_state_t;

endpackage

// File: rtl/ecdc_burst_sizer.sv
module ecdc_burst_sizer #(
  parameter int BUS_W     = 32,
  parameter int BLK_BEATS = 4,
  parameter int ESC_W     = 3,
  parameter int HDR_BITS  = 32,
  parameter int REC_BITS  = 16,
  parameter int LEN_W     = 3
) (
  input  logic [ESC_W-1:0] esc,
  output logic [LEN_W-1:0] beats
);

  localparam logic [ESC_W-1:0] ESC_UNC = '1;

  int bits_total;
  int beats_raw;

  always_comb begin
    bits_total = HDR_BITS + REC_BITS * int'(esc);
    beats_raw  = (bits_total + BUS_W - 1) / BUS_W;
    if (esc == ESC_UNC || beats_raw >= BLK_BEATS)
      beats = LEN_W'(BLK_BEATS);
    else
      beats = LEN_W'(beats_raw);
  end

endmodule

// File: rtl/ecdc_esc_table.sv
module ecdc_esc_table #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int ESC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [ESC_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [ESC_W-1:0] wr_data,
  output logic             ready
);

  localparam logic [ESC_W-1:0] ESC_UNC = '1;

  logic [ESC_W-1:0] store [DEPTH];
  logic [IDX_W-1:0] sweep;
  logic             we;
  logic [IDX_W-1:0] wa;
  logic [ESC_W-1:0] wd;

  // clearing sweep owns the write port until it finishes
  always_comb begin
    we = !ready || wr_en;
    wa = ready ? wr_addr : sweep;
    wd = ready ? wr_data : ESC_UNC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      sweep <= sweep + 1'b1;
      if (sweep == IDX_W'(DEPTH - 1)) ready <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) store[wa] <= wd;
    rd_data <= store[rd_addr];
  end

  // R1
  init_excl_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ready);

endmodule

// File: rtl/ecdc_ctrl.sv
module ecdc_ctrl #(
  parameter int BUS_W     = 32,
  parameter int BLK_BEATS = 4,
  parameter int NBLK      = 16,
  parameter int ESC_W     = 3,
  parameter int HDR_BITS  = 32,
  parameter int REC_BITS  = 16,
  parameter int IDX_W     = $clog2(NBLK),
  parameter int BLK_W     = BUS_W * BLK_BEATS,
  parameter int LEN_W     = $clog2(BLK_BEATS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [IDX_W-1:0] miss_blk,
  input  logic [IDX_W-1:0] vict_blk,
  input  logic [BLK_W-1:0] vict_data,
  output logic             fill_valid,
  output logic [IDX_W-1:0] fill_blk,
  output logic [BLK_W-1:0] fill_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [IDX_W-1:0] mem_req_blk,
  output logic [LEN_W-1:0] mem_req_len,
  input  logic             mem_rd_valid,
  input  logic [BUS_W-1:0] mem_rd_data,
  output logic             mem_wr_valid,
  input  logic             mem_wr_ready,
  output logic [BUS_W-1:0] mem_wr_data,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic [ESC_W-1:0] dec_esc,
  output logic [BLK_W-1:0] dec_data,
  input  logic             dec_done,
  input  logic [BLK_W-1:0] dec_out,
  output logic             cmp_valid,
  input  logic             cmp_ready,
  output logic [BLK_W-1:0] cmp_data,
  input  logic             cmp_done,
  input  logic [ESC_W-1:0] cmp_esc,
  input  logic [BLK_W-1:0] cmp_out
);

  import ecdc_pkg::*;

  localparam logic [ESC_W-1:0] ESC_UNC = '1;

  ctl_state_t       state;
  logic [IDX_W-1:0] req_q, vict_q;
  logic [BLK_W-1:0] vbuf, rbuf, rbuf_ins, wbuf, fill_data_q;
  logic [ESC_W-1:0] esc_q, wesc_q, tbl_rd;
  logic [LEN_W-1:0] cnt, rd_len, wr_len;
  logic             fill_valid_q, tbl_ready, tbl_we;

  ecdc_esc_table #(.DEPTH(NBLK), .IDX_W(IDX_W), .ESC_W(ESC_W)) u_table (
    .clk(clk), .rst(rst),
    .rd_addr(miss_blk), .rd_data(tbl_rd),
    .wr_en(tbl_we), .wr_addr(vict_q), .wr_data(wesc_q),
    .ready(tbl_ready)
  );

  ecdc_burst_sizer #(.BUS_W(BUS_W), .BLK_BEATS(BLK_BEATS), .ESC_W(ESC_W),
    .HDR_BITS(HDR_BITS), .REC_BITS(REC_BITS), .LEN_W(LEN_W)) u_rd_size (
    .esc(esc_q), .beats(rd_len)
  );

  ecdc_burst_sizer #(.BUS_W(BUS_W), .BLK_BEATS(BLK_BEATS), .ESC_W(ESC_W),
    .HDR_BITS(HDR_BITS), .REC_BITS(REC_BITS), .LEN_W(LEN_W)) u_wr_size (
    .esc(wesc_q), .beats(wr_len)
  );

  // interface decode from the state register
  always_comb begin
    miss_ready    = tbl_ready && (state == ST_IDLE);
    mem_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
    mem_req_write = (state == ST_WR_REQ);
    mem_req_blk   = mem_req_write ? vict_q : req_q;
    mem_req_len   = mem_req_write ? wr_len : rd_len;
    mem_wr_valid  = (state == ST_WR_DAT);
    mem_wr_data   = wbuf[int'(cnt) * BUS_W +: BUS_W];
    dec_valid     = (state == ST_DEC_REQ);
    dec_esc       = esc_q;
    dec_data      = rbuf;
    cmp_valid     = (state == ST_CMP_REQ);
    cmp_data      = vbuf;
    fill_valid    = fill_valid_q;
    fill_blk      = req_q;
    fill_data     = fill_data_q;
    tbl_we        = (state == ST_WR_REQ) && mem_req_ready;
  end

  always_comb begin
    rbuf_ins = rbuf;
    rbuf_ins[int'(cnt) * BUS_W +: BUS_W] = mem_rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      fill_valid_q <= 1'b0;
      cnt          <= '0;
    end else begin
      case (state)
        ST_IDLE: if (miss_valid && miss_ready) begin
          req_q  <= miss_blk;
          vict_q <= vict_blk;
          vbuf   <= vict_data;
          state  <= ST_LOOK;
        end
        ST_LOOK: begin
          esc_q <= tbl_rd;
          state <= ST_RD_REQ;
        end
        ST_RD_REQ: if (mem_req_ready) begin
          rbuf  <= '0;
          cnt   <= '0;
          state <= ST_RD_DAT;
        end
        ST_RD_DAT: if (mem_rd_valid) begin
          rbuf <= rbuf_ins;
          cnt  <= cnt + 1'b1;
          if (cnt == rd_len - LEN_W'(1)) begin
            if (esc_q == ESC_UNC) begin
              fill_data_q  <= rbuf_ins;
              fill_valid_q <= 1'b1;
              state        <= ST_FILL;
            end else begin
              state <= ST_DEC_REQ;
            end
          end
        end
        ST_DEC_REQ: if (dec_ready) state <= ST_DEC_WAIT;
        ST_DEC_WAIT: if (dec_done) begin
          fill_data_q  <= dec_out;
          fill_valid_q <= 1'b1;
          state        <= ST_FILL;
        end
        ST_FILL: begin
          fill_valid_q <= 1'b0;
          state        <= ST_CMP_REQ;
        end
        ST_CMP_REQ: if (cmp_ready) state <= ST_CMP_WAIT;
        ST_CMP_WAIT: if (cmp_done) begin
          wesc_q <= cmp_esc;
          wbuf   <= (cmp_esc == ESC_UNC) ? vbuf : cmp_out;
          state  <= ST_WR_REQ;
        end
        ST_WR_REQ: if (mem_req_ready) begin
          cnt   <= '0;
          state <= ST_WR_DAT;
        end
        ST_WR_DAT: if (mem_wr_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == wr_len - LEN_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_len != '0) && (int'(mem_req_len) <= BLK_BEATS));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_blk)
      && $stable(mem_req_len) && $stable(mem_req_write));

  // R6
  dec_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> dec_esc != ESC_UNC);

  // R2
  holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> !miss_ready);

  // R7
  fill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !fill_valid);

  // R7
  fill_before_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> cmp_valid);

endmodule

// File: tb/ecdc_ctrl_test.sv
`timescale 1ns/1ps
module ecdc_ctrl_test;

  localparam int BW = 32;
  localparam int NB = 16;
  localparam int BK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         miss_valid = 1'b0, miss_ready;
  logic [3:0]   miss_blk = '0, vict_blk = '0;
  logic [127:0] vict_data = '0;
  logic         fill_valid;
  logic [3:0]   fill_blk;
  logic [127:0] fill_data;
  logic         mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [3:0]   mem_req_blk;
  logic [2:0]   mem_req_len;
  logic         mem_rd_valid = 1'b0;
  logic [31:0]  mem_rd_data = '0;
  logic         mem_wr_valid, mem_wr_ready = 1'b0;
  logic [31:0]  mem_wr_data;
  logic         dec_valid, dec_ready = 1'b0, dec_done = 1'b0;
  logic [2:0]   dec_esc;
  logic [127:0] dec_data, dec_out = '0;
  logic         cmp_valid, cmp_ready = 1'b0, cmp_done = 1'b0;
  logic [2:0]   cmp_esc = '0;
  logic [127:0] cmp_data, cmp_out = '0;

  ecdc_ctrl uut (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_blk(miss_blk),
    .vict_blk(vict_blk), .vict_data(vict_data),
    .fill_valid(fill_valid), .fill_blk(fill_blk), .fill_data(fill_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_blk(mem_req_blk), .mem_req_len(mem_req_len),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_data(mem_wr_data),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_esc(dec_esc), .dec_data(dec_data),
    .dec_done(dec_done), .dec_out(dec_out),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_data(cmp_data),
    .cmp_done(cmp_done), .cmp_esc(cmp_esc), .cmp_out(cmp_out)
  );

  typedef struct { int blk; logic [127:0] data; int rlen; int decs; int esc; } fill_item_t;
  typedef struct { int blk; int len; logic [127:0] data; } wr_item_t;

  fill_item_t   fill_q[$];
  wr_item_t     wr_q[$];
  int           cesc_q[$];
  logic [127:0] ref_blk [NB];
  logic [127:0] mem_blk [NB];
  int           esc_ref [NB];
  int n_chk = 0, n_fail = 0;
  int exp_decs = 0, dec_cnt = 0, last_dec_esc = -1, last_rd_len = 0;
  int fills_seen = 0, cmps_seen = 0;
  bit done = 1'b0;

  function automatic int blen(int e);
    int b;
    if (e >= 7) return BK;
    b = (32 + 16 * e + BW - 1) / BW;
    return (b > BK) ? BK : b;
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_miss(int rq, int vb, logic [127:0] vd, int ce);
    fill_item_t fi;
    wr_item_t   wi;
    logic [127:0] pad;
    int rl, wl;
    rl  = blen(esc_ref[rq]);
    pad = '0;
    for (int k = 0; k < rl; k++) pad[k*BW +: BW] = ref_blk[rq][k*BW +: BW];
    fi.blk  = rq;
    fi.rlen = rl;
    fi.esc  = esc_ref[rq];
    fi.data = (esc_ref[rq] == 7) ? pad : ~pad;
    if (esc_ref[rq] != 7) exp_decs++;
    fi.decs = exp_decs;
    fill_q.push_back(fi);
    wl = blen(ce);
    wi.blk  = vb;
    wi.len  = wl;
    wi.data = (ce == 7) ? vd : ~vd;
    wr_q.push_back(wi);
    cesc_q.push_back(ce);
    for (int k = 0; k < wl; k++) ref_blk[vb][k*BW +: BW] = wi.data[k*BW +: BW];
    esc_ref[vb] = ce;
    @(negedge clk);
    miss_valid = 1'b1;
    miss_blk   = 4'(rq);
    vict_blk   = 4'(vb);
    vict_data  = vd;
    while (!miss_ready) @(negedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  // memory model
  initial begin
    int stall, blk, len;
    bit wr;
    wr_item_t wi;
    stall = 0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (stall) @(negedge clk);
        stall = (stall + 1) % 3;
        mem_req_ready = 1'b1;
        blk = int'(mem_req_blk);
        len = int'(mem_req_len);
        wr  = mem_req_write;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (!wr) begin
          last_rd_len = len;
          for (int k = 0; k < len; k++) begin
            if (k == 1) begin mem_rd_valid = 1'b0; @(negedge clk); end
            mem_rd_valid = 1'b1;
            mem_rd_data  = mem_blk[blk][k*BW +: BW];
            @(negedge clk);
          end
          mem_rd_valid = 1'b0;
        end else begin
          if (wr_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected write", 128'(blk), 0);
          end else begin
            wi = wr_q.pop_front();
            chk(blk == wi.blk, "R8", "write block", 128'(blk), 128'(wi.blk));
            chk(len == wi.len, "R8", "write length", 128'(len), 128'(wi.len));
            for (int k = 0; k < len; k++) begin
              if (k == 1) begin mem_wr_ready = 1'b0; @(negedge clk); end
              mem_wr_ready = 1'b1;
              while (!mem_wr_valid) @(negedge clk);
              if (k == 0) chk(!miss_ready, "R2", "miss_ready during write-back", 128'(miss_ready), 0);
              chk(mem_wr_data == wi.data[k*BW +: BW], "R9", "write beat",
                  128'(mem_wr_data), 128'(wi.data[k*BW +: BW]));
              mem_blk[blk][k*BW +: BW] = mem_wr_data;
              @(negedge clk);
            end
            mem_wr_ready = 1'b0;
          end
        end
      end
    end
  end

  // decompressor model
  initial begin
    logic [127:0] cap;
    forever begin
      @(negedge clk);
      if (dec_valid) begin
        dec_ready    = 1'b1;
        cap          = dec_data;
        last_dec_esc = int'(dec_esc);
        dec_cnt++;
        @(negedge clk);
        dec_ready = 1'b0;
        dec_done  = 1'b1;
        dec_out   = ~cap;
        @(negedge clk);
        dec_done = 1'b0;
      end
    end
  end

  // compressor model
  initial begin
    logic [127:0] cap;
    int ce;
    forever begin
      @(negedge clk);
      if (cmp_valid) begin
        cmps_seen++;
        chk(fills_seen == cmps_seen, "R7", "compress after fill", 128'(fills_seen), 128'(cmps_seen));
        cmp_ready = 1'b1;
        cap = cmp_data;
        ce  = (cesc_q.size() != 0) ? cesc_q.pop_front() : 0;
        @(negedge clk);
        cmp_ready = 1'b0;
        cmp_done  = 1'b1;
        cmp_esc   = 3'(ce);
        cmp_out   = ~cap;
        @(negedge clk);
        cmp_done = 1'b0;
      end
    end
  end

  // scoreboard monitor on the fill side
  initial begin
    fill_item_t fi;
    forever begin
      @(negedge clk);
      if (!rst && fill_valid) begin
        fills_seen++;
        if (fill_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected fill", 128'(fill_blk), 0);
        end else begin
          fi = fill_q.pop_front();
          chk(int'(fill_blk) == fi.blk, "R7", "fill block", 128'(fill_blk), 128'(fi.blk));
          chk(last_rd_len == fi.rlen, "R3", "read length", 128'(last_rd_len), 128'(fi.rlen));
          chk(dec_cnt == fi.decs, (fi.esc == 7) ? "R6" : "R5", "decompressor uses",
              128'(dec_cnt), 128'(fi.decs));
          if (fi.esc != 7)
            chk(last_dec_esc == fi.esc, "R5", "dec_esc", 128'(last_dec_esc), 128'(fi.esc));
          chk(fill_data == fi.data, (fi.esc == 7) ? "R6" : "R5", "fill data", fill_data, fi.data);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R2", "watchdog expired", 0, 0);
      report();
    end
  end

  initial begin
    int n;
    for (int i = 0; i < NB; i++) begin
      esc_ref[i] = 7;
      for (int k = 0; k < BK; k++) ref_blk[i][k*BW +: BW] = 32'hA000_0000 | 32'(i << 8) | 32'(k);
      mem_blk[i] = ref_blk[i];
    end
    repeat (3) @(negedge clk);
    chk(!miss_ready && !fill_valid && !mem_req_valid, "R1", "reset outputs",
        128'({miss_ready, fill_valid, mem_req_valid}), 0);
    rst = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!miss_ready && n < 100);
    chk(n == NB, "R1", "init sweep cycles", 128'(n), 128'(NB));

    do_miss(3, 5, 128'h0123_4567_89AB_CDEF_1111_2222_3333_4444, 0); // R1 unwritten block, R4 e=0
    do_miss(5, 6, 128'h5555_6666_7777_8888_9999_AAAA_BBBB_CCCC, 1); // R4 e=1
    do_miss(6, 7, 128'hDEAD_BEEF_CAFE_F00D_0BAD_F00D_FEED_FACE, 3); // R4 e=3
    do_miss(7, 8, 128'h1357_9BDF_2468_ACE0_FFFF_0000_AAAA_5555, 6); // R4 e=6 cap
    do_miss(8, 9, 128'h0F0F_0F0F_F0F0_F0F0_3C3C_3C3C_C3C3_C3C3, 7); // R9 raw write
    do_miss(9, 9, 128'h7777_1111_2222_3333_4444_5555_6666_0000, 2); // R6 raw read, R8 same block
    do_miss(9, 15, 128'h8000_0001_4000_0002_2000_0004_1000_0008, 5); // R4 e=2, e=5
    do_miss(15, 0, 128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0000_1111, 4); // R4 e=4
    do_miss(0, 3, 128'h1234_5678_1234_5678_1234_5678_1234_5678, 0);
    do_miss(3, 12, 128'h9876_5432_1098_7654_3210_FEDC_BA98_7654, 7); // R8 updated count
    do_miss(12, 1, 128'h0000_0000_0000_0000_0000_0000_0000_0001, 6);

    n = 0;
    while ((fill_q.size() != 0 || wr_q.size() != 0 || !miss_ready) && n < 1000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    chk(fill_q.size() == 0 && wr_q.size() == 0, "R2", "all misses completed",
        128'(fill_q.size() + wr_q.size()), 0);
    done = 1'b1;
    report();
  end

endmodule